// File: doc/BRIEF.md
# Gated Infrared Mode Configuration Registers

This block holds the control and status registers that choose the operating mode of an infrared link controller. Software writes a mode word and a physical-layer timing word into "pending" registers. Those values do not reach the datapath while they are being edited. They become the active configuration only at the moment the global IR enable goes from 0 to 1. At that edge the mode word and the timing word are each copied into an active register. The active copies then drive the decoded configuration outputs.

The block also reports status through the enable register. That status covers which encoding is running, whether the transmit and receive paths are live, whether the short CRC is in use, and whether the applied mode selection was illegal. The bus is a single-cycle write port plus a combinational read port, each with a small word address.

Top module: `irmode_gate_top`

## Requirements
- R1: After synchronous active-low reset, every readable register reads 0x0000 and every decoded output is 0.
- R2: The mode word at address 0 stores writes and reads them back masked with 0x5EFF. Its bit positions are: loopback 14, transmit enable 12, receive enable 11, master 10, receive-any 9, short CRC 7, fast 6, medium 5, slow 4, slow-filter 3, filter-test 2, transmit invert 1, receive invert 0.
- R3: The enable register at address 1 has a writable bit 15 (enable). Its bits 14..8 are read-only: 14 error, 13 fast on, 12 medium on, 11 slow on, 10 transmit status, 9 receive status, 8 short-CRC on. Bits 7..0 read as 0, and writes to bits 14..0 have no effect.
- R4: Transmit status (enable register bit 10 and `tx_active`) equals the stored transmit-enable bit at all times.
- R5: Receive status (enable register bit 9 and `rx_active`) equals receive-enable AND (NOT transmit-enable OR loopback), taken from the stored mode word.
- R6: On a write that sets bit 15 while enable is 0, exactly one selected mode bit among fast, medium and slow turns on the matching on-status bit. The short-CRC on bit then follows the short-CRC bit of that applied word.
- R7: If that applied word selects none, or more than one, of fast, medium and slow, the error bit is set and no mode-on bit is asserted.
- R8: The pending timing word at address 2 is copied to address 3 and to the `phy_*` outputs at the enable's rising edge. The baud field sits in bits 15..10, the pulse width in bits 9..5 and the preamble in bits 4..0. Writes to address 3 are ignored.
- R9: Writes to addresses 0 and 2 while enable is 1 change the read-back of those registers but leave the active configuration, the address 3 copy and the mode status untouched. Writing 1 to an already-set enable does not re-apply.
- R10: Clearing enable drops the mode-on, short-CRC on and error bits. The address 3 copy keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 16 | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 16 | Read data (combinational) |
| ir_enable | output | 1 | Global IR enable |
| fir_on | output | 1 | Fast mode active |
| mir_on | output | 1 | Medium mode active |
| sir_on | output | 1 | Slow mode active |
| crc16_on | output | 1 | Short CRC active |
| cfg_error | output | 1 | Illegal mode applied |
| tx_active | output | 1 | Transmit status |
| rx_active | output | 1 | Receive status |
| active_cfg | output | 16 | Mode word applied at last rising edge |
| phy_baud | output | 6 | Applied baud divisor field |
| phy_width | output | 5 | Applied pulse width field |
| phy_preamble | output | 5 | Applied preamble field |

## Verification
The bench sweeps every combination of the three mode bits and the short-CRC bit through a rising edge. A decoder that lets an empty or doubled selection through would assert a mode-on bit beside the error flag. The bench also sweeps all eight transmit/receive/loopback combinations. A wrong receive rule would show receive status while transmitting without loopback. It then rewrites the pending registers and re-sets enable while enable is already high. A design that applies on level rather than edge would change the active copy or the status at that point. A design that clears the wrong state on disable would lose the address 3 copy or keep the mode bits lit.

// File: rtl/irg_pkg.sv
// Package: shared register addresses, bit positions and the mode legality rule
// for the gated IR mode configuration block. Assumes 16-bit registers.
package irg_pkg;
    localparam int REG_W = 16;

    localparam int ADDR_CFG  = 0;
    localparam int ADDR_EN   = 1;
    localparam int ADDR_NPHY = 2;
    localparam int ADDR_CPHY = 3;

    // mode word bit positions
    localparam int CB_LOOP  = 14;
    localparam int CB_TXEN  = 12;
    localparam int CB_RXEN  = 11;
    localparam int CB_CRC16 = 7;
    localparam int CB_FAST  = 6;
    localparam int CB_MED   = 5;
    localparam int CB_SLOW  = 4;
    localparam logic [REG_W-1:0] CFG_MASK = 16'h5EFF;

    // enable register bit positions
    localparam int EB_EN   = 15;
    localparam int EB_ERR  = 14;
    localparam int EB_FAST = 13;
    localparam int EB_MED  = 12;
    localparam int EB_SLOW = 11;
    localparam int EB_TX   = 10;
    localparam int EB_RX   = 9;
    localparam int EB_CRC  = 8;

    // timing word fields
    localparam int BAUD_W = 6;
    localparam int PW_W   = 5;
    localparam int PRE_W  = 5;
    localparam int PRE_LSB  = 0;
    localparam int PW_LSB   = PRE_LSB + PRE_W;
    localparam int BAUD_LSB = PW_LSB + PW_W;

    typedef struct packed {
        logic err;
        logic fast;
        logic med;
        logic slow;
        logic crc16;
    } mode_stat_t;

    // A mode word is legal only when exactly one encoding bit is selected.
    function automatic logic mode_is_bad(input logic [REG_W-1:0] cfg);
        return $countones({cfg[CB_FAST], cfg[CB_MED], cfg[CB_SLOW]}) != 1;
    endfunction
endpackage

// File: rtl/irg_regfile.sv
// Module: pending register storage and the enable bit.
// Holds the mode word, the pending timing word and the enable flag, and flags
// the write that raises enable from 0 (the only moment a config is applied).
// Assumes single-cycle writes; reads are handled elsewhere.
module irg_regfile
    import irg_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  cfg_q,
    output logic [REG_W-1:0]  nphy_q,
    output logic              en_q,
    output logic              apply_o
);
    logic hit_cfg, hit_en, hit_nphy;

    // Address decode for the writable registers.
    always_comb begin
        hit_cfg  = wr_en && (wr_addr == ADDR_W'(ADDR_CFG));
        hit_en   = wr_en && (wr_addr == ADDR_W'(ADDR_EN));
        hit_nphy = wr_en && (wr_addr == ADDR_W'(ADDR_NPHY));
        apply_o  = hit_en && wr_data[EB_EN] && !en_q;
    end

    // Store writes; undefined mode bits are dropped at the store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            nphy_q <= '0;
            en_q   <= 1'b0;
        end else begin
            if (hit_cfg)  cfg_q  <= wr_data & CFG_MASK;
            if (hit_nphy) nphy_q <= wr_data;
            if (hit_en)   en_q   <= wr_data[EB_EN];
        end
    end
endmodule

// File: rtl/irg_apply.sv
// Module: active configuration capture and mode decode.
// Copies the mode and timing words on the apply pulse, judges the mode legal
// or not, and gates all mode status with the live enable.
// Assumes apply_i is only asserted on the 0->1 enable write.
module irg_apply
    import irg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply_i,
    input  logic             en_i,
    input  logic [REG_W-1:0] cfg_i,
    input  logic [REG_W-1:0] nphy_i,
    output logic [REG_W-1:0] act_cfg_o,
    output logic [REG_W-1:0] act_phy_o,
    output mode_stat_t       stat_o
);
    logic [REG_W-1:0] act_cfg_q, act_phy_q;
    logic             bad_q;

    // Snapshot the pending words at the rising edge of enable only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cfg_q <= '0;
            act_phy_q <= '0;
            bad_q     <= 1'b0;
        end else if (apply_i) begin
            act_cfg_q <= cfg_i;
            act_phy_q <= nphy_i;
            bad_q     <= mode_is_bad(cfg_i);
        end
    end

    // Mode status: visible only while enabled, suppressed on an illegal mode.
    always_comb begin
        stat_o.err   = en_i && bad_q;
        stat_o.fast  = en_i && !bad_q && act_cfg_q[CB_FAST];
        stat_o.med   = en_i && !bad_q && act_cfg_q[CB_MED];
        stat_o.slow  = en_i && !bad_q && act_cfg_q[CB_SLOW];
        stat_o.crc16 = en_i && act_cfg_q[CB_CRC16];
        act_cfg_o    = act_cfg_q;
        act_phy_o    = act_phy_q;
    end

    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat_o.fast, stat_o.med, stat_o.slow})); // R6
    AST_ERR_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o.err |-> !(stat_o.fast || stat_o.med || stat_o.slow)); // R7
    AST_OFF_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !(stat_o.fast || stat_o.med || stat_o.slow || stat_o.err || stat_o.crc16)); // R10
    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_i |=> ($stable(act_phy_q) && $stable(act_cfg_q))); // R9
endmodule

// File: rtl/irg_status.sv
// Module: live transmit/receive status and the read-data multiplexer.
// Composes the enable/status word and selects the addressed register.
// Assumes unmapped addresses read as zero.
module irg_status
    import irg_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [REG_W-1:0]  cfg_i,
    input  logic [REG_W-1:0]  nphy_i,
    input  logic [REG_W-1:0]  act_phy_i,
    input  logic              en_i,
    input  mode_stat_t        stat_i,
    output logic              tx_st_o,
    output logic              rx_st_o,
    output logic [REG_W-1:0]  rd_data_o
);
    logic [REG_W-1:0] en_word;

    // Transmit/receive status from the stored mode word.
    always_comb begin
        tx_st_o = cfg_i[CB_TXEN];
        rx_st_o = cfg_i[CB_RXEN] && (!cfg_i[CB_TXEN] || cfg_i[CB_LOOP]);
    end

    // Enable/status word; low byte always reads zero.
    always_comb begin
        en_word          = '0;
        en_word[EB_EN]   = en_i;
        en_word[EB_ERR]  = stat_i.err;
        en_word[EB_FAST] = stat_i.fast;
        en_word[EB_MED]  = stat_i.med;
        en_word[EB_SLOW] = stat_i.slow;
        en_word[EB_TX]   = tx_st_o;
        en_word[EB_RX]   = rx_st_o;
        en_word[EB_CRC]  = stat_i.crc16;
    end

    // Read multiplexer.
    always_comb begin
        if (rd_addr == ADDR_W'(ADDR_CFG))       rd_data_o = cfg_i;
        else if (rd_addr == ADDR_W'(ADDR_EN))   rd_data_o = en_word;
        else if (rd_addr == ADDR_W'(ADDR_NPHY)) rd_data_o = nphy_i;
        else if (rd_addr == ADDR_W'(ADDR_CPHY)) rd_data_o = act_phy_i;
        else                                    rd_data_o = '0;
    end

    AST_RX_NEEDS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_st_o && rx_st_o) |-> cfg_i[CB_LOOP]); // R5
endmodule

// File: rtl/irmode_gate_top.sv
// Module: top of the gated IR mode configuration registers.
// Ties pending storage, edge-gated capture and status/read logic together and
// decodes the active configuration for the datapath.
// Assumes ADDR_W >= 2 so all four registers are reachable.
module irmode_gate_top
    import irg_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    output logic              ir_enable,
    output logic              fir_on,
    output logic              mir_on,
    output logic              sir_on,
    output logic              crc16_on,
    output logic              cfg_error,
    output logic              tx_active,
    output logic              rx_active,
    output logic [15:0]       active_cfg,
    output logic [5:0]        phy_baud,
    output logic [4:0]        phy_width,
    output logic [4:0]        phy_preamble
);
    logic [REG_W-1:0] cfg_q, nphy_q, act_phy;
    logic             en_q, apply;
    mode_stat_t       stat;

    irg_regfile #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg_q(cfg_q), .nphy_q(nphy_q), .en_q(en_q),
        .apply_o(apply)
    );

    irg_apply apply_i (
        .clk(clk), .rst_n(rst_n), .apply_i(apply), .en_i(en_q),
        .cfg_i(cfg_q), .nphy_i(nphy_q), .act_cfg_o(active_cfg),
        .act_phy_o(act_phy), .stat_o(stat)
    );

    irg_status #(.ADDR_W(ADDR_W)) status_i (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .cfg_i(cfg_q),
        .nphy_i(nphy_q), .act_phy_i(act_phy), .en_i(en_q), .stat_i(stat),
        .tx_st_o(tx_active), .rx_st_o(rx_active), .rd_data_o(rd_data)
    );

    // Decoded outputs toward the datapath.
    always_comb begin
        ir_enable    = en_q;
        fir_on       = stat.fast;
        mir_on       = stat.med;
        sir_on       = stat.slow;
        crc16_on     = stat.crc16;
        cfg_error    = stat.err;
        phy_baud     = act_phy[BAUD_LSB +: BAUD_W];
        phy_width    = act_phy[PW_LSB +: PW_W];
        phy_preamble = act_phy[PRE_LSB +: PRE_W];
    end

    AST_APPLY_RAISES_EN: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> en_q); // R6
endmodule

// File: tb/irmode_gate_top_tb_top.sv
module irmode_gate_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        ir_enable, fir_on, mir_on, sir_on, crc16_on, cfg_error;
    logic        tx_active, rx_active;
    logic [15:0] active_cfg;
    logic [5:0]  phy_baud;
    logic [4:0]  phy_width, phy_preamble;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    irmode_gate_top #(.ADDR_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ir_enable(ir_enable), .fir_on(fir_on), .mir_on(mir_on),
        .sir_on(sir_on), .crc16_on(crc16_on), .cfg_error(cfg_error),
        .tx_active(tx_active), .rx_active(rx_active), .active_cfg(active_cfg),
        .phy_baud(phy_baud), .phy_width(phy_width), .phy_preamble(phy_preamble)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // Expected enable/status word from stored fields.
    function automatic logic [15:0] en_word(input bit en, input bit err, input bit f,
        input bit m, input bit s, input bit tx, input bit rx, input bit crc);
        return {en, err, f, m, s, tx, rx, crc, 8'h00};
    endfunction

    initial begin
        logic [15:0] v;
        logic [15:0] phy_keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reg", v, 16'h0000);
        end
        chk("R1 outputs", {ir_enable, fir_on, mir_on, sir_on, crc16_on, cfg_error,
            tx_active, rx_active, 8'h00}, 16'h0000);
        chk("R1 phy", {phy_baud, phy_width, phy_preamble}, 16'h0000);

        // R2: mode word masking sweep
        for (int i = 0; i < 16; i++) begin
            logic [15:0] p;
            p = 16'((i * 16'h1357) ^ (i << 9) ^ 16'hA5A0);
            wr(2'd0, p);
            rd(2'd0, v);
            chk("R2 mask", v, p & 16'h5EFF);
        end

        // R3: read-only bits of the enable register ignore writes
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h7FFF);
        rd(2'd1, v);
        chk("R3 ro bits", v, 16'h0000);

        // R4/R5: transmit/receive status rule
        for (int c = 0; c < 8; c++) begin
            bit t, r, l;
            t = c[0]; r = c[1]; l = c[2];
            wr(2'd0, 16'((int'(l) << 14) | (int'(t) << 12) | (int'(r) << 11)));
            rd(2'd1, v);
            chk("R4 tx status", {15'd0, v[10]}, {15'd0, t});
            chk("R5 rx status", {15'd0, v[9]}, {15'd0, r & (~t | l)});
            chk("R5 rx port", {14'd0, tx_active, rx_active}, {14'd0, t, r & (~t | l)});
        end

        // R6/R7/R8: apply every mode selection with both CRC settings
        for (int m = 0; m < 8; m++) begin
            for (int crc = 0; crc < 2; crc++) begin
                bit f, me, s, err;
                logic [15:0] cw, pw;
                f = m[2]; me = m[1]; s = m[0];
                err = (int'(f) + int'(me) + int'(s)) != 1;
                cw = 16'((m << 4) | (crc << 7));
                pw = 16'((m * 16'h0C63) ^ (crc * 16'h8421) ^ 16'h1234);
                wr(2'd1, 16'h0000);
                wr(2'd0, cw);
                wr(2'd2, pw);
                wr(2'd1, 16'h8000);
                rd(2'd1, v);
                chk(err ? "R7 status word" : "R6 status word", v,
                    en_word(1'b1, err, f & ~err, me & ~err, s & ~err, 1'b0, 1'b0, crc[0]));
                chk(err ? "R7 ports" : "R6 ports",
                    {10'd0, cfg_error, fir_on, mir_on, sir_on, crc16_on, ir_enable},
                    {10'd0, err, f & ~err, me & ~err, s & ~err, crc[0], 1'b1});
                rd(2'd3, v);
                chk("R8 current phy", v, pw);
                chk("R8 phy fields", {phy_baud, phy_width, phy_preamble}, pw);
                chk("R6 active cfg", active_cfg, cw);
            end
        end

        // R9: edits while enabled do not reach the active configuration
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0050);      // fast + slow -> would be illegal
        wr(2'd2, 16'h5555);
        wr(2'd1, 16'h8000);      // applies: error
        rd(2'd1, v);
        chk("R7 illegal pair", v, en_word(1, 1, 0, 0, 0, 0, 0, 0));
        wr(2'd0, 16'h0020);      // medium alone, written while enabled
        wr(2'd2, 16'h0ABC);
        wr(2'd3, 16'hFFFF);      // read-only copy
        wr(2'd1, 16'h8000);      // already set: no re-apply
        rd(2'd1, v);
        chk("R9 status held", v, en_word(1, 1, 0, 0, 0, 0, 0, 0));
        rd(2'd3, v);
        chk("R9 phy held", v, 16'h5555);
        chk("R9 active held", active_cfg, 16'h0050);
        rd(2'd0, v);
        chk("R9 cfg readback", v, 16'h0020);
        rd(2'd2, v);
        chk("R9 nphy readback", v, 16'h0ABC);

        // R10: clearing enable drops status, keeps current phy copy
        wr(2'd1, 16'h0000);
        rd(2'd1, v);
        chk("R10 status off", v, 16'h0000);
        rd(2'd3, v);
        chk("R10 phy kept", v, 16'h5555);
        phy_keep = v;
        wr(2'd1, 16'h8000);      // new rising edge applies the edits
        rd(2'd1, v);
        chk("R6 medium on", v, en_word(1, 0, 0, 1, 0, 0, 0, 0));
        rd(2'd3, v);
        chk("R8 new phy", v, 16'h0ABC);
        chk("R8 changed", {15'd0, v != phy_keep}, 16'h0001);

        done = 1;
    end

    initial begin
        for (int n = 0; n < 20000 && !done; n++) @(negedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule